// File: doc/BRIEF.md
# Time-Wheel Event Queue

This block keeps pending simulation events, each carrying an absolute time and a payload, and hands them back in time order. It uses a bucket queue instead of a sorted structure. Time advances in steps of one unit. A ring of `WHEEL_LEN` buckets covers the `WHEEL_LEN` time steps that start at the current time. Events further out wait in a small unsorted overflow store. Each bucket is a short FIFO that holds every pending event for one time step. The bucket is chosen from the low bits of the event time.

A producer offers events on a valid/ready insert port. A consumer takes them from a valid/ready pop port, which shows the current time next to the payload at the head of the current bucket. When the current bucket is empty, a scanner moves forward one bucket per clock. When it steps past the last bucket, the time base grows by one wheel span. On each such wrap, every overflow entry that now falls inside the window is moved into its bucket, one entry per clock. Pops and inserts are held off until that move is done. An event whose time is already behind the current time is accepted, dropped and reported on an error pulse.

Top module: `twq_top`

## Requirements
- R1: After reset, `empty` is 1, `popValid` is 0, `curTime` is 0 and `insReady` is 1.
- R2: An event with `curTime <= insTime < curTime + WHEEL_LEN` goes into bucket `insTime mod WHEEL_LEN`. Every accepted, non-late event is later presented exactly once. Each pop presents the smallest time still pending.
- R3: An event with `insTime >= curTime + WHEEL_LEN` is kept in the overflow store. It is presented later with its own time.
- R4: Events with equal time that were inserted straight into the wheel leave in insertion order.
- R5: When the target bucket already holds `BKT_DEPTH` (4) events, `insReady` is 0 for an insert aimed at it.
- R6: When the overflow store holds `FAR_DEPTH` (8) events, `insReady` is 0 for a far insert. Inserts that fall inside the window are still accepted.
- R7: An insert with `insTime < curTime` is accepted and discarded. `insErr` is 1 in the cycle after acceptance and 0 otherwise.
- R8: `curTime` never moves by more than one step per clock. `popValid` is 0 while the scanner passes over empty buckets. `popTime` equals `curTime`.
- R9: After bucket `WHEEL_LEN-1`, the index returns to 0 and the base grows by `WHEEL_LEN`. Overflow entries that fall inside the new window move into the wheel, and `popValid` and `insReady` stay 0 until that move is done.
- R10: `empty` is 1 exactly when the wheel and the overflow store hold no event. While empty, `curTime` holds.
- R11: While `popValid` is 1 and `popReady` is 0, the presented event and `curTime` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Insert request |
| insTime | input | TIME_W | Absolute event time |
| insData | input | DATA_W | Event payload |
| insReady | output | 1 | Insert can be taken this cycle |
| insErr | output | 1 | Pulse: the previous accepted insert was late |
| popReady | input | 1 | Consumer takes the presented event |
| popValid | output | 1 | An event is presented |
| popTime | output | TIME_W | Time of the presented event |
| popData | output | DATA_W | Payload of the presented event |
| curTime | output | TIME_W | Current scan time |
| empty | output | 1 | No event pending anywhere |

## Verification
A corrupted bucket pointer or count shows up at the first pop from that bucket, either as a payload that was never inserted or as a lost event. A wrong base or index shows up within one cycle as a `curTime` jump, or at the next pop as a time that is not the pending minimum. A missed migration shows up within one wheel span of scanning. By then an overflow event has been skipped, so a later pop presents a larger time while the model still holds the smaller one. A faulty gate during migration shows up as a `popValid` or `insReady` high in the cycle right after a wrap.

// File: rtl/twq_pkg.sv
package twq_pkg;

  // One-cycle commands from the control to the datapath
  typedef struct packed {
    logic pushWheel;  // write the insert port into its bucket
    logic pushFar;    // write the insert port into a free overflow slot
    logic popHead;    // drop the head of the current bucket
    logic migrate;    // move one in-window overflow entry into the wheel
    logic advance;    // step the scan index (and base on wrap)
  } twq_strobe_t;

endpackage

// File: rtl/twq_bucket.sv
module twq_bucket #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] headData,
  output logic              isEmpty,
  output logic              isFull
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTRW-1:0]   rdPtr, wrPtr;
  logic [CNTW-1:0]   count;

  function automatic logic [PTRW-1:0] nextPtr(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];
  assign isEmpty  = (count == '0);
  assign isFull   = (count == CNTW'(DEPTH));

  // R5
  bkt_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !isFull);

  // R2
  bkt_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !isEmpty);

endmodule

// File: rtl/twq_datapath.sv
module twq_datapath
  import twq_pkg::*;
#(
  parameter int TIME_W    = 16,
  parameter int DATA_W    = 8,
  parameter int WHEEL_LEN = 16,
  parameter int BKT_DEPTH = 4,
  parameter int FAR_DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  twq_strobe_t          strobe,
  input  logic [TIME_W-1:0]    insTime,
  input  logic [DATA_W-1:0]    insData,
  output logic [TIME_W-1:0]    curTime,
  output logic [DATA_W-1:0]    popData,
  output logic [WHEEL_LEN-1:0] bktEmpty,
  output logic [WHEEL_LEN-1:0] bktFull,
  output logic                 farFull,
  output logic                 farAny,
  output logic                 migValid
);
  localparam int IDXW = $clog2(WHEEL_LEN);
  localparam int HIW  = TIME_W - IDXW;
  localparam int FARW = (FAR_DEPTH > 1) ? $clog2(FAR_DEPTH) : 1;

  // scan position: time = {baseHi, curIdx}, one unit per quantum
  logic [HIW-1:0]  baseHi;
  logic [IDXW-1:0] curIdx;

  // overflow store
  logic [FAR_DEPTH-1:0] farValid;
  logic [TIME_W-1:0]    farTime [FAR_DEPTH];
  logic [DATA_W-1:0]    farData [FAR_DEPTH];
  logic [FAR_DEPTH-1:0] fitVec;
  logic [FARW-1:0]      freeSlot, migSlot;
  logic [IDXW-1:0]      migIdx;
  logic [DATA_W-1:0]    migData;

  logic [DATA_W-1:0] headArr [WHEEL_LEN];

  assign curTime = {baseHi, curIdx};
  assign farFull = &farValid;
  assign farAny  = |farValid;

  always_comb begin
    freeSlot = '0;
    for (int j = FAR_DEPTH - 1; j >= 0; j--)
      if (!farValid[j]) freeSlot = FARW'(j);
  end

  // an entry may move when it is in the current lap and its bucket has room
  always_comb begin
    for (int j = 0; j < FAR_DEPTH; j++)
      fitVec[j] = farValid[j] && (farTime[j][TIME_W-1:IDXW] == baseHi)
                  && !bktFull[farTime[j][IDXW-1:0]];
  end

  always_comb begin
    migSlot = '0;
    for (int j = FAR_DEPTH - 1; j >= 0; j--)
      if (fitVec[j]) migSlot = FARW'(j);
  end

  assign migValid = |fitVec;
  assign migIdx   = farTime[migSlot][IDXW-1:0];
  assign migData  = farData[migSlot];

  for (genvar g = 0; g < WHEEL_LEN; g++) begin : g_bkt
    logic bPush, bPop;
    logic [DATA_W-1:0] bData;
    assign bPush = (strobe.pushWheel && (insTime[IDXW-1:0] == IDXW'(g)))
                || (strobe.migrate && (migIdx == IDXW'(g)));
    assign bData = strobe.migrate ? migData : insData;
    assign bPop  = strobe.popHead && (curIdx == IDXW'(g));
    twq_bucket #(.DATA_W(DATA_W), .DEPTH(BKT_DEPTH)) u_bkt (
      .clk      (clk),
      .rstN     (rstN),
      .push     (bPush),
      .pushData (bData),
      .pop      (bPop),
      .headData (headArr[g]),
      .isEmpty  (bktEmpty[g]),
      .isFull   (bktFull[g])
    );
  end

  assign popData = headArr[curIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      farValid <= '0;
    end else begin
      if (strobe.pushFar) farValid[freeSlot] <= 1'b1;
      if (strobe.migrate) farValid[migSlot]  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.pushFar) begin
      farTime[freeSlot] <= insTime;
      farData[freeSlot] <= insData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi <= '0;
      curIdx <= '0;
    end else if (strobe.advance) begin
      if (curIdx == IDXW'(WHEEL_LEN - 1)) begin
        curIdx <= '0;
        baseHi <= baseHi + 1'b1;
      end else begin
        curIdx <= curIdx + 1'b1;
      end
    end
  end

  // R8
  scan_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curTime) |-> (curTime == $past(curTime) + TIME_W'(1)));

  // R9
  wrap_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.advance) && ($past(curIdx) == IDXW'(WHEEL_LEN - 1)))
      |-> (curIdx == '0 && baseHi == $past(baseHi) + 1'b1));

  // R9
  mig_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.migrate |-> !(strobe.popHead || strobe.pushWheel || strobe.pushFar || strobe.advance));

  for (genvar j = 0; j < FAR_DEPTH; j++) begin : g_farChk
    // R3
    far_future_chk: assert property (@(posedge clk) disable iff (!rstN)
      farValid[j] |-> (farTime[j][TIME_W-1:IDXW] >= baseHi));
  end

endmodule

// File: rtl/twq_ctrl.sv
module twq_ctrl
  import twq_pkg::*;
#(
  parameter int TIME_W    = 16,
  parameter int WHEEL_LEN = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 insValid,
  input  logic [TIME_W-1:0]    insTime,
  input  logic                 popReady,
  input  logic [TIME_W-1:0]    curTime,
  input  logic [WHEEL_LEN-1:0] bktEmpty,
  input  logic [WHEEL_LEN-1:0] bktFull,
  input  logic                 farFull,
  input  logic                 farAny,
  input  logic                 migValid,
  output twq_strobe_t          strobe,
  output logic                 insReady,
  output logic                 popValid,
  output logic                 empty,
  output logic                 insErr
);
  localparam int IDXW = $clog2(WHEEL_LEN);
  localparam logic [TIME_W:0] WIN = (TIME_W+1)'(WHEEL_LEN);

  logic [IDXW-1:0] curIdx, tgtIdx;
  logic isLate, isFar, hasWork, accept;

  always_comb begin
    curIdx  = curTime[IDXW-1:0];
    tgtIdx  = insTime[IDXW-1:0];
    isLate  = insTime < curTime;
    isFar   = {1'b0, insTime} >= ({1'b0, curTime} + WIN);
    hasWork = !(&bktEmpty) || farAny;

    if (migValid)    insReady = 1'b0;
    else if (isLate) insReady = 1'b1;
    else if (isFar)  insReady = !farFull;
    else             insReady = !bktFull[tgtIdx];
    accept = insValid && insReady;

    strobe           = '0;
    strobe.pushWheel = accept && !isLate && !isFar;
    strobe.pushFar   = accept && isFar;
    popValid         = !migValid && !bktEmpty[curIdx];
    strobe.popHead   = popValid && popReady;
    strobe.migrate   = migValid;
    strobe.advance   = !migValid && bktEmpty[curIdx] && hasWork
                       && !(strobe.pushWheel && (tgtIdx == curIdx));
    empty            = !hasWork;
  end

  always_ff @(posedge clk) begin
    if (!rstN) insErr <= 1'b0;
    else       insErr <= accept && isLate;
  end

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !popValid);

  // R7
  late_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    insErr |-> $past(insValid && insReady && (insTime < curTime)));

  // R11
  pop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && !popReady) |=> (popValid && $stable(curTime)));

endmodule

// File: rtl/twq_top.sv
module twq_top
  import twq_pkg::*;
#(
  parameter int TIME_W    = 16,
  parameter int DATA_W    = 8,
  parameter int WHEEL_LEN = 16,
  parameter int BKT_DEPTH = 4,
  parameter int FAR_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic [TIME_W-1:0] insTime,
  input  logic [DATA_W-1:0] insData,
  output logic              insReady,
  output logic              insErr,
  input  logic              popReady,
  output logic              popValid,
  output logic [TIME_W-1:0] popTime,
  output logic [DATA_W-1:0] popData,
  output logic [TIME_W-1:0] curTime,
  output logic              empty
);
  twq_strobe_t          strobe;
  logic [WHEEL_LEN-1:0] bktEmpty, bktFull;
  logic                 farFull, farAny, migValid;

  twq_ctrl #(.TIME_W(TIME_W), .WHEEL_LEN(WHEEL_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .insValid (insValid),
    .insTime  (insTime),
    .popReady (popReady),
    .curTime  (curTime),
    .bktEmpty (bktEmpty),
    .bktFull  (bktFull),
    .farFull  (farFull),
    .farAny   (farAny),
    .migValid (migValid),
    .strobe   (strobe),
    .insReady (insReady),
    .popValid (popValid),
    .empty    (empty),
    .insErr   (insErr)
  );

  twq_datapath #(
    .TIME_W(TIME_W), .DATA_W(DATA_W), .WHEEL_LEN(WHEEL_LEN),
    .BKT_DEPTH(BKT_DEPTH), .FAR_DEPTH(FAR_DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .insTime  (insTime),
    .insData  (insData),
    .curTime  (curTime),
    .popData  (popData),
    .bktEmpty (bktEmpty),
    .bktFull  (bktFull),
    .farFull  (farFull),
    .farAny   (farAny),
    .migValid (migValid)
  );

  assign popTime = curTime;

endmodule

// File: tb/twq_top_bench.sv
`timescale 1ns/1ps
module twq_top_bench;
  localparam int TW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN, insValid, insReady, insErr, popReady, popValid, empty;
  logic [TW-1:0] insTime, popTime, curTime;
  logic [DW-1:0] insData, popData;

  twq_top u_twq_top (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insTime(insTime),
    .insData(insData), .insReady(insReady), .insErr(insErr),
    .popReady(popReady), .popValid(popValid), .popTime(popTime),
    .popData(popData), .curTime(curTime), .empty(empty)
  );

  int  nChk = 0, nBad = 0;
  bit  finished = 0;
  int  mT [256];
  int  mD [256];
  int  mN = 0;
  bit  expErr = 0;
  int  prevCur = 0;
  bit  lastReady, lastPopValid, popFire;
  int  popD;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int modelMin();
    int m = 32'h7fffffff;
    for (int k = 0; k < mN; k++) if (mT[k] < m) m = mT[k];
    return m;
  endfunction

  // One clock: drive at the falling edge, sample 1 ns later, update the model.
  task automatic step(input bit iv, input int it, input int id, input bit pr);
    bit found, acc, late;
    @(negedge clk);
    insValid = iv; insTime = TW'(it); insData = DW'(id); popReady = pr;
    #1;
    check(insErr == expErr, "R7 insErr", int'(insErr), int'(expErr));
    check(empty == (mN == 0), "R10 empty", int'(empty), int'(mN == 0));
    check(curTime == TW'(prevCur) || curTime == TW'(prevCur + 1), "R8 step",
          int'(curTime), prevCur);
    prevCur      = int'(curTime);
    lastReady    = insReady;
    lastPopValid = popValid;
    popFire      = popValid && pr;
    popD         = int'(popData);
    if (popValid) begin
      check(popTime == curTime, "R8 popTime", int'(popTime), int'(curTime));
      check(int'(popTime) == modelMin(), "R2 min", int'(popTime), modelMin());
    end
    if (popFire) begin
      found = 0;
      for (int k = 0; k < mN; k++) begin
        if (!found && mT[k] == int'(popTime) && mD[k] == int'(popData)) begin
          found = 1;
          mT[k] = mT[mN-1]; mD[k] = mD[mN-1]; mN--;
        end
      end
      check(found, "R2 known event", int'(popData), -1);
    end
    acc    = iv && insReady;
    late   = TW'(it) < curTime;
    expErr = acc && late;
    if (acc && !late) begin
      mT[mN] = it & 32'hffff; mD[mN] = id & 32'hff; mN++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nBad++; nChk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    bit seenWrap;
    int t, near;
    rstN = 0; insValid = 0; insTime = '0; insData = '0; popReady = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    check(empty == 1'b1, "R1 empty", int'(empty), 1);
    check(popValid == 1'b0, "R1 popValid", int'(popValid), 0);
    check(curTime == '0, "R1 curTime", int'(curTime), 0);
    check(insReady == 1'b1, "R1 insReady", int'(insReady), 1);

    // R5 fill one bucket, R4 order within it
    for (int k = 0; k < 4; k++) begin
      step(1, 3, 10 + k, 0);
      check(lastReady, "R5 accept", int'(lastReady), 1);
    end
    step(1, 3, 99, 0);
    check(!lastReady, "R5 full bucket", int'(lastReady), 0);
    for (int k = 0; k < 4; k++) begin
      popFire = 0;
      for (int w = 0; w < 40 && !popFire; w++) step(0, 0, 0, 1);
      check(popFire && popD == 10 + k, "R4 order", popD, 10 + k);
    end

    // R7 late insert is dropped
    step(0, 0, 0, 0);
    step(1, int'(curTime) - 1, 55, 0);
    check(lastReady, "R7 late accepted", int'(lastReady), 1);
    step(0, 0, 0, 0);
    check(insErr == 1'b1 && empty == 1'b1, "R7 flag and no event", int'(insErr), 1);

    // R3 far store, R6 far capacity
    for (int k = 0; k < 8; k++) begin
      step(1, 30 + k, 20 + k, 0);
      check(lastReady, "R3 far accept", int'(lastReady), 1);
    end
    step(1, 60, 99, 0);
    check(!lastReady, "R6 far full", int'(lastReady), 0);
    near = int'(curTime) + 2;
    step(1, near, 77, 0);
    check(lastReady, "R6 near still accepted", int'(lastReady), 1);

    // R9 drain through the wraps, watching the migration gate
    seenWrap = 0;
    for (int w = 0; w < 300 && mN > 0; w++) begin
      step(0, 0, 0, 1);
      if (!seenWrap && curTime == TW'(16)) begin
        seenWrap = 1;
        check(!lastPopValid && !lastReady, "R9 gate after wrap",
              int'(lastPopValid) + int'(lastReady), 0);
      end
    end
    check(seenWrap, "R9 wrap seen", int'(seenWrap), 1);
    check(mN == 0, "R3 far events delivered", mN, 0);

    // R11 hold under back-pressure
    step(1, int'(curTime) + 2, 88, 0);
    for (int w = 0; w < 20 && !lastPopValid; w++) step(0, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 0, 0);
      check(lastPopValid && popD == 88, "R11 hold", popD, 88);
    end
    step(0, 0, 0, 1);
    check(popFire, "R11 release", int'(popFire), 1);

    // constrained random mix
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0 && curTime > 0) t = int'(curTime) - 1;
      else t = int'(curTime) + int'($urandom_range(0, 40));
      step(bit'($urandom_range(0, 1)), t, int'($urandom_range(0, 255)),
           $urandom_range(0, 9) < 6);
    end
    for (int w = 0; w < 3000 && mN > 0; w++) step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    check(mN == 0 && empty, "R2 all delivered", mN, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule